// File: doc/BRIEF.md
# Packed Byte String Access Unit

This unit reads or writes one byte of a string whose bytes are packed two to a 16-bit memory word. A command carries a word base pointer, a byte index, an 8-bit instruction offset and, for writes, a data operand. The unit adds the offset to the index. It halves that sum and adds the base to get the word address. The low bit of the sum picks the byte inside the word, and the byte order inside a word is big-endian: an even index selects the high byte.

A read fetches the word and returns the selected byte zero-extended to 16 bits. A write is a read-modify-write. The unit fetches the word, replaces only the selected byte with the low byte of the data operand, and stores the word back, so the neighbouring byte is preserved.

The command side is a valid/ready stream. `cmd_ready` is high only while the unit is idle. A command transfers on a cycle where both `cmd_valid` and `cmd_ready` are high. While an access is in flight `cmd_ready` stays low, which holds off any further command, so only one access is ever outstanding. The memory side uses a request/acknowledge handshake: the request and its address, direction and store data stay fixed until an acknowledge arrives, and read data is taken in the cycle of the acknowledge. Completion is a plain one-cycle `done` pulse, and the pulse has no back-pressure.

Top module: `byte_string_unit`

## Requirements
- R1: After reset `cmd_ready` is 1 and `mem_req` and `done` are 0. `cmd_ready` is 1 only while no access is in flight, and a command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both 1.
- R2: The byte index is `cmd_index + cmd_offset` (offset zero-extended), computed in 16 bits; any carry out of bit 15 is dropped.
- R3: The word address is `cmd_base + (byte index >> 1)`, taken modulo 2^16. It is presented on `mem_addr` for every memory request of the command.
- R4: When the byte index is even, bits 15:8 of the word are selected. When it is odd, bits 7:0 are selected.
- R5: A read (`cmd_write`=0) issues exactly one memory request with `mem_we`=0. When `done` is high, `rd_data` holds the selected byte in bits 7:0, and bits 15:8 are zero.
- R6: A write (`cmd_write`=1) issues a fetch (`mem_we`=0) and then a store (`mem_we`=1) to the same address. The stored word keeps the unselected byte of the fetched word unchanged.
- R7: A write puts only `cmd_wdata[7:0]` into the selected byte; `cmd_wdata[15:8]` has no effect on the stored word.
- R8: Once `mem_req` rises, it stays high, and `mem_addr`, `mem_we` and `mem_wdata` stay stable, until a cycle with `mem_ack`=1.
- R9: `done` is high for exactly one cycle, the cycle after the acknowledge of the last memory request of the command. `cmd_ready` returns to 1 in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command can transfer |
| cmd_write | input | 1 | 1 = byte write, 0 = byte read |
| cmd_base | input | 16 | Word base pointer |
| cmd_index | input | 16 | Byte index |
| cmd_offset | input | 8 | Instruction offset added to the index |
| cmd_wdata | input | 16 | Write operand; only bits 7:0 are used |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = store, 0 = fetch |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Store data |
| mem_ack | input | 1 | Request accepted; fetch data valid on mem_rdata |
| mem_rdata | input | 16 | Fetched word |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Zero-extended byte from the last read |

## Verification
The hardest case to reach is a write whose store phase has to wait on a stalled memory while the merged word must stay fixed. The same applies to a write whose index and offset sum carries past bit 15, or whose word address wraps past the top of memory. The bench memory model inserts a random 0 to 2 cycle wait before every acknowledge, which holds both the fetch and the store phases in place for varying times. Directed commands force an index near 0xFFFF, a base near 0xFFFF, and write operands with nonzero upper bits. Write-then-read sequences to the same word check that the other byte is preserved.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2,
    ST_DONE  = 2'd3
  } bsa_state_e;
endpackage

// File: rtl/bsa_addr_gen.sv
module bsa_addr_gen #(
  parameter int WORD_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] index,
  input  logic [OFF_W-1:0]  offset,
  output logic [WORD_W-1:0] word_addr,
  output logic              lane_odd
);
  logic [WORD_W-1:0] byte_idx;

  // sum kept at word width: carry out of the top bit is dropped
  always_comb begin
    byte_idx  = index + WORD_W'(offset);
    word_addr = base + (byte_idx >> 1);
    lane_odd  = byte_idx[0];
  end
endmodule

// File: rtl/bsa_lane.sv
module bsa_lane #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0]   word_in,
  input  logic                lane_odd,
  input  logic [WORD_W/2-1:0] new_byte,
  output logic [WORD_W-1:0]   picked,
  output logic [WORD_W-1:0]   merged
);
  localparam int BYTE_W = WORD_W / 2;

  logic [BYTE_W-1:0] hi_half, lo_half;

  always_comb begin
    hi_half = word_in[WORD_W-1:BYTE_W];
    lo_half = word_in[BYTE_W-1:0];
    if (lane_odd) begin
      picked = {{BYTE_W{1'b0}}, lo_half};
      merged = {hi_half, new_byte};
    end else begin
      picked = {{BYTE_W{1'b0}}, hi_half};
      merged = {new_byte, lo_half};
    end
  end
endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
  import bsa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic is_write,
  input  logic mem_ack,
  output logic cmd_ready,
  output logic take_cmd,
  output logic take_fetch,
  output logic mem_req,
  output logic mem_we,
  output logic done
);
  bsa_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (cmd_valid) state_nx = ST_FETCH;
      ST_FETCH: if (mem_ack) state_nx = is_write ? ST_STORE : ST_DONE;
      ST_STORE: if (mem_ack) state_nx = ST_DONE;
      ST_DONE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign cmd_ready  = (state == ST_IDLE);
  assign take_cmd   = cmd_ready && cmd_valid;
  assign take_fetch = (state == ST_FETCH) && mem_ack;
  assign mem_req    = (state == ST_FETCH) || (state == ST_STORE);
  assign mem_we     = (state == ST_STORE);
  assign done       = (state == ST_DONE);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req && !done);
  a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_ack) && $past(mem_req));
endmodule

// File: rtl/byte_string_unit.sv
module byte_string_unit #(
  parameter int WORD_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [WORD_W-1:0] cmd_base,
  input  logic [WORD_W-1:0] cmd_index,
  input  logic [OFF_W-1:0]  cmd_offset,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [WORD_W-1:0] rd_data
);
  localparam int BYTE_W = WORD_W / 2;

  logic              take_cmd, take_fetch;
  logic [WORD_W-1:0] ag_addr;
  logic              ag_odd;
  logic [WORD_W-1:0] ln_picked, ln_merged;

  logic              r_write;
  logic [WORD_W-1:0] r_addr;
  logic              r_odd;
  logic [BYTE_W-1:0] r_byte;
  logic [WORD_W-1:0] r_store;
  logic [WORD_W-1:0] r_rd;

  bsa_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .is_write   (r_write),
    .mem_ack    (mem_ack),
    .cmd_ready  (cmd_ready),
    .take_cmd   (take_cmd),
    .take_fetch (take_fetch),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .done       (done)
  );

  bsa_addr_gen #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_addr (
    .base      (cmd_base),
    .index     (cmd_index),
    .offset    (cmd_offset),
    .word_addr (ag_addr),
    .lane_odd  (ag_odd)
  );

  bsa_lane #(.WORD_W(WORD_W)) u_lane (
    .word_in  (mem_rdata),
    .lane_odd (r_odd),
    .new_byte (r_byte),
    .picked   (ln_picked),
    .merged   (ln_merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_write <= 1'b0;
      r_addr  <= '0;
      r_odd   <= 1'b0;
      r_byte  <= '0;
      r_store <= '0;
      r_rd    <= '0;
    end else begin
      if (take_cmd) begin
        r_write <= cmd_write;
        r_addr  <= ag_addr;
        r_odd   <= ag_odd;
        r_byte  <= cmd_wdata[BYTE_W-1:0];
      end
      if (take_fetch) begin
        r_store <= ln_merged;
        if (!r_write) r_rd <= ln_picked;
      end
    end
  end

  assign mem_addr  = r_addr;
  assign mem_wdata = r_store;
  assign rd_data   = r_rd;

  a_r8_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_wdata));
  a_r6_store_same_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack && r_write |=>
      mem_req && mem_we && $stable(mem_addr));
  a_r6_keep_other_byte: assert property (@(posedge clk) disable iff (!rst_n)
    take_fetch && r_write |=>
      (r_odd ? (mem_wdata[WORD_W-1:BYTE_W] == $past(mem_rdata[WORD_W-1:BYTE_W]))
             : (mem_wdata[BYTE_W-1:0] == $past(mem_rdata[BYTE_W-1:0]))));
  a_r5_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    done && !r_write |-> rd_data[WORD_W-1:BYTE_W] == '0);
endmodule

// File: tb/tb_byte_string_unit.sv
module tb_byte_string_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [15:0] cmd_base = '0, cmd_index = '0, cmd_wdata = '0;
  logic [7:0]  cmd_offset = '0;
  logic        mem_req, mem_we, done;
  logic [15:0] mem_addr, mem_wdata, rd_data;
  logic        mem_ack;
  logic [15:0] mem_rdata;

  int n_checks = 0, n_errors = 0;

  always #4 clk = ~clk;

  byte_string_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_base(cmd_base), .cmd_index(cmd_index),
    .cmd_offset(cmd_offset), .cmd_wdata(cmd_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .rd_data(rd_data)
  );

  // memory model with random wait before each acknowledge
  logic [15:0] mem [0:255];
  int          wait_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wait_cnt  <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= 16'(i * 16'h9E37) ^ 16'h5A5A;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wait_cnt == 0) begin
          mem_ack   <= 1'b1;
          mem_rdata <= mem[mem_addr[7:0]];
          if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
          wait_cnt  <= int'($urandom % 3);
        end else begin
          wait_cnt <= wait_cnt - 1;
        end
      end
    end
  end

  // transaction log and request-hold monitor
  int          tx_total = 0;
  logic [15:0] tx_addr  [0:7];
  logic        tx_we    [0:7];
  logic [15:0] tx_wdata [0:7];
  int          hold_viol = 0;
  logic        p_pend = 1'b0;
  logic [15:0] p_addr = '0, p_wdata = '0;
  logic        p_we = 1'b0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (p_pend && (!mem_req || mem_addr != p_addr || mem_we != p_we ||
                     mem_wdata != p_wdata))
        hold_viol <= hold_viol + 1;
      if (mem_req && mem_ack) begin
        tx_addr[tx_total[2:0]]  <= mem_addr;
        tx_we[tx_total[2:0]]    <= mem_we;
        tx_wdata[tx_total[2:0]] <= mem_wdata;
        tx_total <= tx_total + 1;
      end
      p_pend  <= mem_req && !mem_ack;
      p_addr  <= mem_addr;
      p_we    <= mem_we;
      p_wdata <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] f_addr(input logic [15:0] b, input logic [15:0] ix,
                                         input logic [7:0] of);
    logic [15:0] s;
    s = ix + {8'h00, of};
    return b + (s >> 1);
  endfunction

  function automatic bit f_odd(input logic [15:0] ix, input logic [7:0] of);
    logic [15:0] s;
    s = ix + {8'h00, of};
    return s[0];
  endfunction

  function automatic logic [15:0] f_pick(input logic [15:0] w, input bit odd);
    return odd ? {8'h00, w[7:0]} : {8'h00, w[15:8]};
  endfunction

  function automatic logic [15:0] f_merge(input logic [15:0] w, input bit odd,
                                          input logic [7:0] b);
    return odd ? {w[15:8], b} : {b, w[7:0]};
  endfunction

  task automatic run_op(input bit wr, input logic [15:0] b, input logic [15:0] ix,
                        input logic [7:0] of, input logic [15:0] wd);
    logic [15:0] ea, old_w, exp_w;
    bit          odd;
    int          t0, n, wt;
    ea    = f_addr(b, ix, of);
    odd   = f_odd(ix, of);
    old_w = mem[ea[7:0]];
    exp_w = f_merge(old_w, odd, wd[7:0]);
    t0    = tx_total;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready when idle", {15'd0, cmd_ready}, 16'd1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_base = b; cmd_index = ix;
    cmd_offset = of; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_base = 16'($urandom); cmd_index = 16'($urandom); cmd_wdata = 16'($urandom);
    wt = 0;
    while (!done && wt < 60) begin
      if (wt > 0 && cmd_ready)
        chk(1'b0, "R1 ready while busy", 16'd1, 16'd0);
      @(negedge clk);
      wt++;
    end
    chk(done == 1'b1, "R9 done reached", {15'd0, done}, 16'd1);
    n = tx_total - t0;
    if (!wr) begin
      chk(n == 1, "R5 one fetch for read", 16'(n), 16'd1);
      chk(tx_addr[t0[2:0]] == ea, "R3 read word address", tx_addr[t0[2:0]], ea);
      chk(tx_we[t0[2:0]] == 1'b0, "R5 read is fetch", {15'd0, tx_we[t0[2:0]]}, 16'd0);
      chk(rd_data == f_pick(old_w, odd), "R4 R5 read byte", rd_data, f_pick(old_w, odd));
    end else begin
      chk(n == 2, "R6 fetch then store", 16'(n), 16'd2);
      chk(tx_we[t0[2:0]] == 1'b0 && tx_we[(t0+1)%8] == 1'b1, "R6 order",
          {14'd0, tx_we[t0[2:0]], tx_we[(t0+1)%8]}, 16'd1);
      chk(tx_addr[t0[2:0]] == ea && tx_addr[(t0+1)%8] == ea, "R3 write word address",
          tx_addr[(t0+1)%8], ea);
      chk(mem[ea[7:0]] == exp_w, "R6 R7 stored word", mem[ea[7:0]], exp_w);
    end
    @(negedge clk);
    chk(done == 1'b0 && cmd_ready == 1'b1, "R9 done one cycle",
        {14'd0, done, cmd_ready}, 16'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'd1, 16'd0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    logic [15:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready == 1'b1 && mem_req == 1'b0 && done == 1'b0, "R1 reset state",
        {13'd0, cmd_ready, mem_req, done}, 16'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1 && mem_req == 1'b0 && done == 1'b0, "R1 after reset",
        {13'd0, cmd_ready, mem_req, done}, 16'h4);

    // R2 carry dropped: index 0xFFFF + 1 -> byte index 0
    run_op(1'b0, 16'h0010, 16'hFFFF, 8'h01, 16'h0);
    // R2 carry dropped, odd result 0x00FD
    run_op(1'b0, 16'h0020, 16'hFFFE, 8'hFF, 16'h0);
    // R3 word address wrap past top
    run_op(1'b0, 16'hFFF0, 16'h0040, 8'h03, 16'h0);
    // R4 even and odd lanes of the same word
    run_op(1'b0, 16'h0030, 16'h0004, 8'h00, 16'h0);
    run_op(1'b0, 16'h0030, 16'h0005, 8'h00, 16'h0);
    // R7 upper bits of operand ignored, both lanes, then read back
    run_op(1'b1, 16'h0050, 16'h0002, 8'h00, 16'hAB12);
    run_op(1'b1, 16'h0050, 16'h0003, 8'h00, 16'hCD34);
    w = mem[8'h51];
    chk(w == 16'h1234, "R6 R7 both bytes written", w, 16'h1234);
    run_op(1'b0, 16'h0050, 16'h0002, 8'h00, 16'h0);
    chk(rd_data == 16'h0012, "R5 read back left", rd_data, 16'h0012);
    run_op(1'b0, 16'h0050, 16'h0000, 8'h03, 16'h0);
    chk(rd_data == 16'h0034, "R5 read back right", rd_data, 16'h0034);
    // R6 write with carry wrap and base wrap
    run_op(1'b1, 16'hFFFF, 16'hFFFF, 8'h03, 16'hFF77);

    for (int k = 0; k < 300; k++)
      run_op(1'($urandom), 16'($urandom), 16'($urandom), 8'($urandom), 16'($urandom));

    chk(hold_viol == 0, "R8 request held until ack", 16'(hold_viol), 16'd0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule